// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a cycle-level, synthesizable model of a single-port synchronous static RAM with a pipelined read path. The depth defaults to 1K words so that it elaborates cheaply. A parameter widens it to 32K words. The data word is split into byte lanes. Every edge of the clock samples two start strobes, three chip enables, an advance input and the write controls, and classifies the cycle. The possible cycles are deselect, begin read, begin access, step and hold.

A begin cycle loads an external address. After that, step cycles walk the two low address bits through a four-word group without touching the upper bits. The walk is either an add-one wrap or an XOR with the step count, chosen by a static order input. Read data passes from the array through an output register, so it shows up one clock after the array access.

The data output is a plain bus with a separate enable. That enable is cut off at once by the active-low output enable or by the active-high sleep input. Sleep also freezes all array activity. When sleep is released, the memory stays idle until a new begin cycle arrives.

Top module: `pburst_sram`

## Requirements
- R1: While reset is high and on the first cycle after it, `rdata_oe` is 0 and `rdata` is 0.
- R2: A read begun at edge n through `cpu_start_n` low (with `en1_n`=0, `en2`=1, `en3_n`=0) drives `rdata` = word at the given address with `rdata_oe`=1 after edge n+1, provided `out_en_n`=0 and `sleep`=0.
- R3: With `wr_all_n`=0 in a cycle begun through `ctl_start_n` (with `cpu_start_n`=1 and all enables active), all byte lanes of the addressed word are written, whatever `lane_wr_n` and `wr_en_n` are. Such a write cycle leaves `rdata_oe`=0 two edges later.
- R4: With `wr_all_n`=1 and `wr_en_n`=0, only the lanes whose bit of `lane_wr_n` is 0 are written; lane i is bits [8i+7:8i]. If every `lane_wr_n` bit is 1, or if `wr_en_n`=1, the cycle is a read.
- R5: A cycle begun through `cpu_start_n` low is always a read, even with the write controls asserted. The word is unchanged and is driven out.
- R6: Deselect takes place when `ctl_start_n`=0 with any enable inactive, or when `cpu_start_n`=0 with `en1_n`=0 and `en2`=0 or `en3_n`=1. After a deselect at edge n, `rdata_oe` is 0 after edge n+1. `cpu_start_n`=0 with `en1_n`=1 is ignored, and the cycle is then decoded from `ctl_start_n` and `advance_n`.
- R7: With `ilv_order`=0, step cycles after a begin at low bits s use low bits (s+1), (s+2), (s+3) mod 4. The upper address bits are kept.
- R8: With `ilv_order`=1, step cycles use low bits s^1, s^2, s^3.
- R9: A hold cycle (both strobes high, `advance_n`=1) accesses the same address as the previous cycle.
- R10: `out_en_n`=1 forces `rdata_oe` to 0 without waiting for a clock edge.
- R11: `sleep`=1 forces `rdata_oe` to 0 without waiting for a clock edge, and blocks writes. After release, step and hold cycles drive no data until a new begin cycle.
- R12: Step and hold cycles that follow a deselect access nothing, and `rdata_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Asynchronous active-high sleep |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| ilv_order | input | 1 | Static burst order: 0 add-one wrap, 1 XOR |
| addr | input | ADDR_W | Word address sampled on begin cycles |
| cpu_start_n | input | 1 | Start strobe that only begins reads; blocked by `en1_n` |
| ctl_start_n | input | 1 | Start strobe that begins reads or writes |
| advance_n | input | 1 | Active-low burst advance |
| en1_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_en_n | input | 1 | Active-low enable for lane writes |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| wdata | input | DATA_W | Write data, sampled on the write edge |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | High when `rdata` should drive the bus |

## Verification
A read begun at edge n produces data after edge n+1: one edge loads the array read register and the next loads the output register. The bench drives pins at falling edges and samples the output two falling edges after the begin. Bursts are checked at one address per falling edge, two edges behind the cycle that named the address. Deselect and write effects on `rdata_oe` are due after the second edge as well. The output enable and sleep effects are combinational, so they are checked one time unit after the pin changes, with no clock edge in between.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CYC_HOLD,
    CYC_STEP,
    CYC_DESEL,
    CYC_CPU_BEGIN,
    CYC_CTL_BEGIN
  } cyc_t;

  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] k,
                                           input logic       ilv);
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
(
  input  logic cpu_start_n,
  input  logic ctl_start_n,
  input  logic advance_n,
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  output cyc_t cyc
);
  logic sel_ok;
  assign sel_ok = !en1_n && en2 && !en3_n;

  always_comb begin
    if (!cpu_start_n && !en1_n)
      cyc = sel_ok ? CYC_CPU_BEGIN : CYC_DESEL;
    else if (!ctl_start_n)
      cyc = sel_ok ? CYC_CTL_BEGIN : CYC_DESEL;
    else if (!advance_n)
      cyc = CYC_STEP;
    else
      cyc = CYC_HOLD;
  end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  input  logic       ilv,
  input  logic [1:0] start_lsb,
  output logic [1:0] cur_lsb
);
  logic [1:0] start_q, k_q, start_use, k_use;

  always_comb begin
    start_use = load ? start_lsb : start_q;
    if (load)      k_use = 2'd0;
    else if (step) k_use = k_q + 2'd1;
    else           k_use = k_q;
  end

  assign cur_lsb = burst_lsb(start_use, k_use, ilv);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      k_q     <= '0;
    end else if (load || step) begin
      start_q <= start_use;
      k_q     <= k_use;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              out_en_n,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              advance_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              wr_all_n,
  input  logic              wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int HI_W = ADDR_W - 2;

  cyc_t              cyc;
  logic              run_q;
  logic [HI_W-1:0]   hi_q;
  logic              begin_c, cont_c, acc, wr_req, is_write, is_read;
  logic [LANES-1:0]  lane_we;
  logic [1:0]        lsb_now;
  logic [ADDR_W-1:0] addr_now;
  logic [DATA_W-1:0] arr_q, dout_q;
  logic              rd_v_q, val_q;

  bsram_decode u_dec (
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .advance_n   (advance_n),
    .en1_n       (en1_n),
    .en2         (en2),
    .en3_n       (en3_n),
    .cyc         (cyc)
  );

  assign begin_c = !sleep && (cyc == CYC_CPU_BEGIN || cyc == CYC_CTL_BEGIN);
  assign cont_c  = !sleep && run_q && (cyc == CYC_STEP || cyc == CYC_HOLD);
  assign acc     = begin_c || cont_c;

  bsram_burst u_burst (
    .clk       (clk),
    .rst       (rst),
    .load      (begin_c),
    .step      (cont_c && cyc == CYC_STEP),
    .ilv       (ilv_order),
    .start_lsb (addr[1:0]),
    .cur_lsb   (lsb_now)
  );

  assign addr_now = begin_c ? addr : {hi_q, lsb_now};

  assign wr_req   = !wr_all_n || (!wr_en_n && !(&lane_wr_n));
  assign is_write = acc && (cyc != CYC_CPU_BEGIN) && wr_req;
  assign is_read  = acc && !is_write;

  always_comb begin
    if (!is_write)      lane_we = '0;
    else if (!wr_all_n) lane_we = '1;
    else                lane_we = ~lane_wr_n;
  end

  bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
    .clk   (clk),
    .we    (rst ? '0 : lane_we),
    .re    (is_read),
    .addr  (addr_now),
    .wdata (wdata),
    .rdata (arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hi_q   <= '0;
      rd_v_q <= 1'b0;
      val_q  <= 1'b0;
      dout_q <= '0;
    end else if (sleep) begin
      run_q  <= 1'b0;
      rd_v_q <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      if (cyc == CYC_DESEL) run_q <= 1'b0;
      else if (begin_c)     run_q <= 1'b1;
      if (begin_c) hi_q <= addr[ADDR_W-1:2];
      rd_v_q <= is_read;
      val_q  <= rd_v_q;
      if (rd_v_q) dout_q <= arr_q;
    end
  end

  assign rdata    = dout_q;
  assign rdata_oe = val_q && !out_en_n && !sleep;
endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep,
  input logic             out_en_n,
  input logic             cpu_start_n,
  input logic             ctl_start_n,
  input logic             en1_n,
  input logic             en2,
  input logic             en3_n,
  input logic             wr_all_n,
  input logic             wr_en_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             rdata_oe
);
  logic all_on, desel_cmd, wr_cmd, rd_cmd;
  assign all_on    = !en1_n && en2 && !en3_n;
  assign desel_cmd = (!ctl_start_n && !all_on) ||
                     (!cpu_start_n && !en1_n && (!en2 || en3_n));
  assign wr_cmd    = !ctl_start_n && cpu_start_n && all_on && !sleep &&
                     (!wr_all_n || (!wr_en_n && (lane_wr_n != '1)));
  assign rd_cmd    = !cpu_start_n && all_on && !sleep;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rdata_oe); // R1

  AST_READ_DUE: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_cmd, 2) && $past(!rst, 2) && $past(!sleep, 1) && $past(!rst, 1) &&
     !sleep && !out_en_n) |-> rdata_oe); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |-> ##2 !rdata_oe); // R3

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (desel_cmd && !sleep) |-> ##2 !rdata_oe); // R6

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rdata_oe); // R10

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !rdata_oe); // R11
endmodule

bind pburst_sram pburst_sram_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep       (sleep),
  .out_en_n    (out_en_n),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .en1_n       (en1_n),
  .en2         (en2),
  .en3_n       (en3_n),
  .wr_all_n    (wr_all_n),
  .wr_en_n     (wr_en_n),
  .lane_wr_n   (lane_wr_n),
  .rdata_oe    (rdata_oe)
);

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst, sleep, out_en_n, ilv_order;
  logic [ADDR_W-1:0] addr;
  logic cpu_start_n, ctl_start_n, advance_n, en1_n, en2, en3_n;
  logic wr_all_n, wr_en_n;
  logic [LANES-1:0] lane_wr_n;
  logic [DATA_W-1:0] wdata, rdata;
  logic rdata_oe;

  int total = 0;
  int bad   = 0;
  logic [DATA_W-1:0] ref_m [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  pburst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .sleep(sleep), .out_en_n(out_en_n), .ilv_order(ilv_order),
    .addr(addr), .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
    .advance_n(advance_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_start_n = 1'b1; ctl_start_n = 1'b1; advance_n = 1'b1;
    en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
    wr_all_n = 1'b1; wr_en_n = 1'b1; lane_wr_n = '1;
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d, input logic gw,
                    input logic we, input logic [LANES-1:0] ln);
    @(negedge clk);
    idle();
    ctl_start_n = 1'b0; addr = a[ADDR_W-1:0]; wdata = d;
    wr_all_n = gw; wr_en_n = we; lane_wr_n = ln;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_check(input int a, input string tag);
    @(negedge clk);
    idle();
    cpu_start_n = 1'b0; addr = a[ADDR_W-1:0];
    @(negedge clk);
    idle();
    @(negedge clk);
    chk({tag, " oe"}, {31'd0, rdata_oe}, 32'd1);
    chk({tag, " data"}, rdata, ref_m[a]);
  endtask

  task automatic burst(input int base, input logic ilv, input bit hold_mid, input string tag);
    int seq [6];
    int last;
    ilv_order = ilv;
    seq[0] = base;
    last   = base;
    for (int j = 1; j < 6; j++) begin
      int k;
      k = hold_mid ? ((j == 1) ? 0 : j - 1) : j;
      if (j > 3 + (hold_mid ? 1 : 0)) seq[j] = last;
      else begin
        int l;
        l = ilv ? ((base & 3) ^ (k & 3)) : (((base & 3) + k) & 3);
        seq[j] = (base & ~3) | l;
      end
      last = seq[j];
    end
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j >= 2) chk(tag, rdata, ref_m[seq[j-2]]);
      idle();
      if (j == 0) begin
        cpu_start_n = 1'b0; addr = base[ADDR_W-1:0];
      end else if (hold_mid && j == 1) begin
        advance_n = 1'b1;
      end else if (j <= (hold_mid ? 4 : 3)) begin
        advance_n = 1'b0;
      end
    end
    @(negedge clk);
    chk(tag, rdata, ref_m[seq[4]]);
    @(negedge clk);
    chk(tag, rdata, ref_m[seq[5]]);
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a);
    return (32'h9e37_79b9 * (a + 1)) ^ (a << 11);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sleep = 1'b0; out_en_n = 1'b0; ilv_order = 1'b0;
    addr = '0; wdata = '0;
    idle();
    @(negedge clk);
    @(negedge clk);
    chk("R1 oe in reset", {31'd0, rdata_oe}, 32'd0);
    chk("R1 data in reset", rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", {31'd0, rdata_oe}, 32'd0);

    // R3: global write fills every word regardless of lane selects
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, pat(a), 1'b0, 1'b1, a[LANES-1:0]);
      ref_m[a] = pat(a);
    end
    for (int a = 0; a < DEPTH; a++) rd_check(a, "R2 R3 read after global write");

    // R4: lane writes under every lane mask, and wr_en_n high
    for (int a = 0; a < DEPTH; a++) begin
      logic [LANES-1:0] m;
      logic [DATA_W-1:0] d;
      logic we;
      m  = a[LANES-1:0];
      we = (a >= 48);
      d  = ~pat(a) ^ 32'h5a5a_a5a5;
      wr(a, d, 1'b1, we, m);
      if (!we) for (int l = 0; l < LANES; l++)
        if (!m[l]) ref_m[a][l*8 +: 8] = d[l*8 +: 8];
    end
    for (int a = 0; a < DEPTH; a++) rd_check(a, "R4 lane write");

    // R5: processor strobe with write controls is a read
    @(negedge clk);
    idle();
    cpu_start_n = 1'b0; addr = 6'd9; wr_all_n = 1'b0; wdata = 32'hdead_beef;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R5 oe", {31'd0, rdata_oe}, 32'd1);
    chk("R5 data", rdata, ref_m[9]);
    rd_check(9, "R5 unchanged");

    // R7 / R8 bursts from every start offset
    for (int s = 0; s < 4; s++) begin
      burst(20 + s, 1'b0, 1'b0, "R7 linear burst");
      burst(40 + s, 1'b1, 1'b0, "R8 interleaved burst");
      burst(32 + s, 1'b0, 1'b1, "R9 hold in burst");
    end
    ilv_order = 1'b0;

    // R6: deselect cases, then R12: continue after deselect
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      idle(); cpu_start_n = 1'b0; addr = 6'd5;
      @(negedge clk);
      idle();
      if (c == 0) begin ctl_start_n = 1'b0; en1_n = 1'b1; end
      if (c == 1) begin cpu_start_n = 1'b0; en3_n = 1'b1; end
      if (c == 2) begin ctl_start_n = 1'b0; en2 = 1'b0; end
      @(negedge clk);
      chk("R6 last read still out", {31'd0, rdata_oe}, 32'd1);
      idle();
      @(negedge clk);
      chk("R6 deselect quiet", {31'd0, rdata_oe}, 32'd0);
      advance_n = 1'b0;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk("R12 step after deselect", {31'd0, rdata_oe}, 32'd0);
      @(negedge clk);
      chk("R12 hold after deselect", {31'd0, rdata_oe}, 32'd0);
    end

    // R6: processor strobe blocked by en1_n; burst continues
    @(negedge clk);
    idle(); cpu_start_n = 1'b0; addr = 6'd17;
    @(negedge clk);
    idle(); cpu_start_n = 1'b0; en1_n = 1'b1; advance_n = 1'b0; addr = 6'd60;
    @(negedge clk);
    chk("R6 ignored start first", rdata, ref_m[17]);
    idle();
    @(negedge clk);
    chk("R6 ignored start continues", rdata, ref_m[18]);

    // R10: output enable gates at once
    rd_check(3, "R10 setup");
    out_en_n = 1'b1; #1;
    chk("R10 oe high", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R10 oe low", {31'd0, rdata_oe}, 32'd1);

    // R11: sleep gates output, blocks writes, idles after release
    rd_check(7, "R11 setup");
    sleep = 1'b1; #1;
    chk("R11 sleep gates", {31'd0, rdata_oe}, 32'd0);
    ctl_start_n = 1'b0; addr = 6'd7; wr_all_n = 1'b0; wdata = 32'h0bad_cafe;
    @(negedge clk);
    idle();
    @(negedge clk);
    sleep = 1'b0; advance_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R11 idle after wake", {31'd0, rdata_oe}, 32'd0);
    rd_check(7, "R11 contents kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule